// File: doc/BRIEF.md
# SPI Master FIFO and DMA Request Controller

This block is the data-path control of an SPI master. Parallel words written from a bus or DMA side enter a transmit queue. A small shift engine serializes them with the clock idle low, changing data on the falling edge and sampling on the rising edge, most significant bit first. Each received word lands in a receive queue. A programmable divider sets the serial clock rate, and at least one idle cycle separates consecutive words.

A 2-bit usage field decides how each queue behaves. In a queue that is switched off, the direction shrinks to a single holding register without flow control, and a new word replaces the one held. Any change of the field empties both queues and withdraws any pending DMA request. The block suspends on its own when the receive queue is full. It reports a busy flag and a separate suspension flag, so software can tell "nothing to send" apart from "stalled on receive". A priority input picks one of two DMA request policies: a request that is withdrawn on each acknowledge, or a request that is held while the queue still needs service.

Top module: `spi_dp_ctrl`

## Requirements
- R1: After synchronous reset, and before the first clock that follows it, rx_empty=1, tx_full=0, busy=0, sck=0, tx_dma_req=0 and rx_dma_req=0.
- R2: Each word is shifted out on mosi most significant bit first, with sck idle low and mosi stable at each rising sck edge. miso is sampled on each rising sck edge, and words taken in loopback reach rx_rdata unchanged and in order.
- R3: With mode=0 (both queues active) the transmit queue holds 4 words. tx_full=1 at 4 entries, and a write while it is full is dropped.
- R4: When a word is pending and the receive queue is full (mode 0 or 1), no transfer starts: busy=0 and rx_stall=1. Reading a word resumes the transfers.
- R5: With mode=1 the transmit side is a single register. A write while it is occupied replaces the held word, and the receive side stays a 4-entry queue that can stall.
- R6: With mode=2 the receive side is a single register. Each new word replaces the held one and never stalls the engine, while the transmit side stays a 4-entry queue.
- R7: With mode=3 both sides are single registers. Of three back-to-back writes only the first and the last are shifted, and rx_rdata ends with the last word.
- R8: With prio=0 a DMA request drops in the cycle after its acknowledge is sampled, and it rises again one cycle later if the queue still needs service.
- R9: With prio=1 tx_dma_req equals "transmit queue not full" and rx_dma_req equals "receive queue not empty", and acknowledges are ignored.
- R10: In the cycle in which the mode input differs from its value at the previous clock, both DMA requests read 0. At the next clock both queues are emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Queue usage: 0 both, 1 receive only, 2 transmit only, 3 none |
| prio | input | 1 | DMA request policy: 0 per acknowledge, 1 held |
| clk_div | input | DIV_W | Serial half-period length minus one, in clocks |
| tx_wr | input | 1 | Write strobe for the transmit side |
| tx_wdata | input | DATA_W | Word to transmit |
| tx_full | output | 1 | Transmit side cannot take a word without loss |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_dma_ack | input | 1 | Transmit DMA acknowledge |
| rx_rd | input | 1 | Read strobe; removes the head word |
| rx_rdata | output | DATA_W | Head word of the receive side |
| rx_empty | output | 1 | Receive side holds no word |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_dma_ack | input | 1 | Receive DMA acknowledge |
| busy | output | 1 | A transfer is running or can start now |
| rx_stall | output | 1 | Transfers suspended on a full receive queue |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The serial path is run in loopback with a table of words holding all-zero, all-one, alternating and single-bit-at-each-end patterns, so that a bit-order error, a stuck bit or a sampling-edge error each shows up as a different mismatch on the word captured at sck and on rx_rdata. The same three back-to-back writes are sent in modes 2 and 3, and the count of shifted words (3 against 2) separates a transmit queue from a single overwriting register. Filling the receive side and then the transmit side separates suspension from an empty queue, shows that the overflow write is dropped, and confirms order after resume. Acknowledge pulses under both priority settings separate the two request policies.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;

    typedef enum logic [1:0] {
        FM_BIDIR   = 2'd0,
        FM_RX_ONLY = 2'd1,
        FM_TX_ONLY = 2'd2,
        FM_NONE    = 2'd3
    } fifo_mode_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_GAP
    } shift_state_e;

    typedef struct packed {
        logic active;
        logic done;
        logic sck;
        logic mosi;
    } shift_stat_t;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int NDIR   = 2;

    // Transmit side degrades to one register when its queue is off
    function automatic logic tx_is_single(fifo_mode_e m);
        return (m == FM_RX_ONLY) || (m == FM_NONE);
    endfunction

    function automatic logic rx_is_single(fifo_mode_e m);
        return (m == FM_TX_ONLY) || (m == FM_NONE);
    endfunction

endpackage

// File: rtl/spi_dp_fifo.sv
module spi_dp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         single,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp, fill;
    logic          do_pop, do_push, overwrite;

    assign fill      = wp - rp;
    assign empty     = (wp == rp);
    assign full      = single ? !empty : (fill == PW'(DEPTH));
    assign do_pop    = pop && !empty;
    assign overwrite = single && push && !empty && !do_pop;
    assign do_push   = push && !overwrite && (!full || do_pop);
    assign rdata     = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + PW'(1);
            if (do_pop)  rp <= rp + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)   mem[wp[AW-1:0]] <= wdata;
        if (overwrite) mem[rp[AW-1:0]] <= wdata;
    end

endmodule

// File: rtl/spi_dp_shift.sv
module spi_dp_shift import spi_dp_pkg::*; #(
    parameter int W     = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [W-1:0]     tx_word,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             miso,
    output shift_stat_t      stat,
    output logic [W-1:0]     rx_word
);
    localparam int BW = $clog2(W);

    shift_state_e     state;
    logic [DIV_W-1:0] div_cnt;
    logic [BW-1:0]    bit_cnt;
    logic [W-1:0]     tx_sr, rx_sr;
    logic             tick, last, done_q;

    assign tick = (div_cnt == clk_div);
    assign last = (bit_cnt == BW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SH_IDLE;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                SH_IDLE: if (start) begin
                    tx_sr   <= tx_word;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    state   <= SH_LOW;
                end
                SH_LOW: begin
                    div_cnt <= div_cnt + DIV_W'(1);
                    if (tick) begin
                        div_cnt <= '0;
                        rx_sr   <= {rx_sr[W-2:0], miso};
                        state   <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    div_cnt <= div_cnt + DIV_W'(1);
                    if (tick) begin
                        div_cnt <= '0;
                        if (last) begin
                            done_q <= 1'b1;
                            state  <= SH_GAP;
                        end else begin
                            bit_cnt <= bit_cnt + BW'(1);
                            tx_sr   <= {tx_sr[W-2:0], 1'b0};
                            state   <= SH_LOW;
                        end
                    end
                end
                SH_GAP: state <= SH_IDLE;
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign stat.active = (state != SH_IDLE);
    assign stat.done   = done_q;
    assign stat.sck    = (state == SH_HIGH);
    assign stat.mosi   = tx_sr[W-1];
    assign rx_word     = rx_sr;

endmodule

// File: rtl/spi_dp_dreq.sv
module spi_dp_dreq (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic prio,
    input  logic need,
    input  logic ack,
    output logic req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst || flush || prio) req_q <= 1'b0;
        else if (ack)             req_q <= 1'b0;
        else                      req_q <= need;
    end

    assign req = !flush && (prio ? need : req_q);

endmodule

// File: rtl/spi_dp_ctrl.sv
module spi_dp_ctrl import spi_dp_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              prio,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              tx_dma_req,
    input  logic              tx_dma_ack,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_empty,
    output logic              rx_dma_req,
    input  logic              rx_dma_ack,
    output logic              busy,
    output logic              rx_stall,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    fifo_mode_e        mode_e, mode_q;
    logic              flush, tx_single, rx_single;
    logic              tx_empty, rx_full, tx_avail, rx_space, start;
    logic [DATA_W-1:0] tx_head, rx_word;
    shift_stat_t       sh;
    logic [NDIR-1:0]   need, ack, req;

    assign mode_e    = fifo_mode_e'(mode);
    assign flush     = (mode_e != mode_q);
    assign tx_single = tx_is_single(mode_e);
    assign rx_single = rx_is_single(mode_e);

    // Previous usage setting; a difference marks a flush cycle
    always_ff @(posedge clk) mode_q <= mode_e;

    spi_dp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush), .single(tx_single),
        .push(tx_wr), .pop(start), .wdata(tx_wdata),
        .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_dp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush), .single(rx_single),
        .push(sh.done), .pop(rx_rd), .wdata(rx_word),
        .rdata(rx_rdata), .full(rx_full), .empty(rx_empty)
    );

    assign tx_avail = !tx_empty;
    assign rx_space = !rx_full || rx_single;
    assign start    = !sh.active && tx_avail && rx_space && !flush;
    assign busy     = sh.active || (tx_avail && rx_space);
    assign rx_stall = !sh.active && tx_avail && !rx_space;

    spi_dp_shift #(.W(DATA_W), .DIV_W(DIV_W)) u_sh (
        .clk(clk), .rst(rst), .start(start), .tx_word(tx_head),
        .clk_div(clk_div), .miso(miso), .stat(sh), .rx_word(rx_word)
    );

    assign sck  = sh.sck;
    assign mosi = sh.mosi;

    assign need[DIR_TX] = !tx_full;
    assign need[DIR_RX] = !rx_empty;
    assign ack[DIR_TX]  = tx_dma_ack;
    assign ack[DIR_RX]  = rx_dma_ack;

    for (genvar d = 0; d < NDIR; d++) begin : g_dreq
        spi_dp_dreq u_dreq (
            .clk(clk), .rst(rst), .flush(flush), .prio(prio),
            .need(need[d]), .ack(ack[d]), .req(req[d])
        );
    end

    assign tx_dma_req = req[DIR_TX];
    assign rx_dma_req = req[DIR_RX];

endmodule

// File: rtl/spi_dp_ctrl_chk.sv
module spi_dp_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       prio,
    input logic       tx_dma_ack,
    input logic       rx_dma_ack,
    input logic       tx_dma_req,
    input logic       rx_dma_req,
    input logic       tx_full,
    input logic       rx_empty,
    input logic       rx_rd,
    input logic       busy,
    input logic       rx_stall,
    input logic       sck
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_empty && !busy && !sck && !rx_dma_req));

    // R2
    idle_sck_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_stall && !rx_rd && $stable(mode)) |=> (!$stable(mode) || rx_stall));

    // R8
    low_prio_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!prio && !$past(prio) && $past(tx_dma_ack)) |-> !tx_dma_req);

    // R8
    low_prio_rx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!prio && !$past(prio) && $past(rx_dma_ack)) |-> !rx_dma_req);

    // R9
    high_prio_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (prio && $stable(mode) && !tx_full) |-> tx_dma_req);

    // R9
    high_prio_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (prio && $stable(mode) && !rx_empty) |-> rx_dma_req);

    // R10
    flush_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> (!tx_dma_req && !rx_dma_req));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |=> rx_empty);

endmodule

bind spi_dp_ctrl spi_dp_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode), .prio(prio),
    .tx_dma_ack(tx_dma_ack), .rx_dma_ack(rx_dma_ack),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_full(tx_full), .rx_empty(rx_empty), .rx_rd(rx_rd),
    .busy(busy), .rx_stall(rx_stall), .sck(sck)
);

// File: tb/tb_spi_dp_ctrl.sv
module tb_spi_dp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81, 8'h6E};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       prio = 1'b0;
    logic [3:0] clk_div = 4'd1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       tx_full, tx_dma_req, rx_empty, rx_dma_req, busy, rx_stall, sck, mosi;
    logic       tx_dma_ack = 1'b0;
    logic       rx_dma_ack = 1'b0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_rdata;
    logic       miso;

    int total = 0;
    int bad = 0;
    int rises = 0;
    logic [7:0] cap = '0;

    assign miso = mosi;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge sck) begin
        cap   <= {cap[6:0], mosi};
        rises <= rises + 1;
    end

    spi_dp_ctrl dut (
        .clk(clk), .rst(rst), .mode(mode), .prio(prio), .clk_div(clk_div),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .tx_dma_req(tx_dma_req), .tx_dma_ack(tx_dma_ack),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
        .rx_dma_req(rx_dma_req), .rx_dma_ack(rx_dma_ack),
        .busy(busy), .rx_stall(rx_stall), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_tx(input logic [7:0] b);
        tx_wr = 1'b1;
        tx_wdata = b;
        step();
        tx_wr = 1'b0;
    endtask

    task automatic pop_rx();
        rx_rd = 1'b1;
        step();
        rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) step();
    endtask

    task automatic wait_rx();
        for (int k = 0; k < 3000 && rx_empty; k++) step();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int r0;
        logic [7:0] seq [8];
        logic [7:0] m1 [5];

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: state right after reset
        chk("R1", "rx_empty", rx_empty, 1);
        chk("R1", "tx_full", tx_full, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "sck", sck, 0);
        chk("R1", "tx_dma_req", tx_dma_req, 0);
        chk("R1", "rx_dma_req", rx_dma_req, 0);

        // R8: low priority, request per acknowledge
        step();
        chk("R8", "tx req armed", tx_dma_req, 1);
        tx_dma_ack = 1'b1;
        step();
        tx_dma_ack = 1'b0;
        chk("R8", "tx req dropped after ack", tx_dma_req, 0);
        step();
        chk("R8", "tx req re-armed", tx_dma_req, 1);

        // R2: loopback table in mode 0
        for (int i = 0; i < NVEC; i++) begin
            write_tx(VEC[i]);
            wait_idle();
            chk("R2", "serial bits msb first", cap, VEC[i]);
            chk("R2", "loopback word", rx_rdata, VEC[i]);
            pop_rx();
        end
        chk("R2", "rx empty after table", rx_empty, 1);

        // R3, R4, R9: fill receive side then transmit side
        prio = 1'b1;
        seq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
        for (int i = 0; i < 4; i++) write_tx(seq[i]);
        wait_idle();
        chk("R4", "no stall with empty tx", rx_stall, 0);
        chk("R9", "rx req held", rx_dma_req, 1);
        rx_dma_ack = 1'b1;
        step();
        rx_dma_ack = 1'b0;
        chk("R9", "rx req ignores ack", rx_dma_req, 1);
        write_tx(seq[4]);
        chk("R4", "busy while suspended", busy, 0);
        chk("R4", "stall flag", rx_stall, 1);
        for (int i = 5; i < 8; i++) write_tx(seq[i]);
        chk("R3", "tx full at 4", tx_full, 1);
        chk("R9", "tx req low when full", tx_dma_req, 0);
        write_tx(8'h99);
        for (int i = 0; i < 8; i++) begin
            wait_rx();
            chk("R3", "order after resume", rx_rdata, seq[i]);
            pop_rx();
        end
        wait_idle();
        chk("R3", "overflow write dropped", rx_empty, 1);

        // R10: mode change flushes and clears requests
        write_tx(8'hC3);
        wait_idle();
        chk("R10", "rx req before change", rx_dma_req, 1);
        mode = 2'd2;
        #1;
        chk("R10", "tx req masked", tx_dma_req, 0);
        chk("R10", "rx req masked", rx_dma_req, 0);
        step();
        chk("R10", "rx flushed", rx_empty, 1);
        chk("R9", "tx req back after flush", tx_dma_req, 1);
        prio = 1'b0;

        // R6: mode 2, single receive register, three words shifted
        r0 = rises;
        write_tx(8'h61);
        write_tx(8'h62);
        write_tx(8'h63);
        wait_idle();
        chk("R6", "three words shifted", rises - r0, 24);
        chk("R6", "last word held", rx_rdata, 8'h63);
        pop_rx();
        chk("R6", "single entry drained", rx_empty, 1);

        // R7: mode 3, both single
        mode = 2'd3;
        step();
        r0 = rises;
        write_tx(8'h71);
        write_tx(8'h72);
        write_tx(8'h73);
        wait_idle();
        chk("R7", "two words shifted", rises - r0, 16);
        chk("R7", "last word held", rx_rdata, 8'h73);
        pop_rx();

        // R5: mode 1, single transmit register, receive queue stalls
        mode = 2'd1;
        step();
        m1 = '{8'h81, 8'h82, 8'h83, 8'h84, 8'h8B};
        for (int i = 0; i < 4; i++) begin
            write_tx(m1[i]);
            wait_idle();
        end
        write_tx(8'h8A);
        write_tx(8'h8B);
        chk("R5", "stalled on rx", rx_stall, 1);
        chk("R5", "tx register occupied", tx_full, 1);
        for (int i = 0; i < 5; i++) begin
            wait_rx();
            chk("R5", "word order with overwrite", rx_rdata, m1[i]);
            pop_rx();
        end
        wait_idle();
        chk("R5", "replaced word never sent", rx_empty, 1);

        finish_run();
    end

endmodule